// File: doc/BRIEF.md
# Stream-to-Memory Packet Capture Engine

This block takes packets arriving on an AXI4-Stream input and stores each one in a memory buffer through a simple word-addressed write port. Software hands the block buffers as descriptors. Each descriptor holds a base word address and a capacity in words. Descriptors are loaded through a small register-style control port that is separate from the data path, and they wait in a four-entry queue.

While a packet is arriving, the block counts its bytes from TKEEP. It writes each beat to the next word of the current buffer. On the TLAST beat it closes the buffer and pushes a completion entry holding the byte length and a status field. It then moves to the next descriptor and pulses an interrupt. Software drains completions by reading a register, and it clears the sticky interrupt flag by writing a one to it.

A packet larger than its buffer is cut short. The beats that do not fit are still accepted but are thrown away up to TLAST, and the completion entry carries a truncation flag.

Top module: `pkt_capture`

## Requirements
- R1: After reset, s_tready_o is 0, irq_o is 0, the status register (address 3) reads 0 and the completion register (address 2) reads 0.
- R2: s_tready_o is 0 while no descriptor is queued, while the completion queue holds 4 entries, or while mem_stall_i is 1 (unless the current packet is being discarded). No memory write happens in a cycle where mem_stall_i is 1.
- R3: The k-th accepted beat of a packet (k from 0) is written to word address base+k, with mem_data_o equal to the beat data and mem_be_o equal to TKEEP.
- R4: The packet length is the sum of the TKEEP one-bits over the written beats. It reads back in bits [15:0] of the completion register.
- R5: A TLAST beat retires the head descriptor, so the next packet is written from the next descriptor's base.
- R6: Beats past the capacity are not written. They are accepted and discarded up to TLAST, and the completion sets bit 16 (truncated). The length counts only the bytes written, and the next packet is captured normally.
- R7: A completion whose length is 0 sets bit 17 (empty).
- R8: Accepting a TLAST beat makes irq_o 1 for the following cycle and sets status bit 0. Writing 1 to status bit 0 clears it. A set in the same cycle as the clear wins.
- R9: Writing address 0 stages a base address. Writing address 1 pushes {staged base, capacity = wdata[11:0]} into the descriptor queue. When the queue already holds 4 entries, the push is ignored. Status bits [6:4] give the queued descriptor count.
- R10: Reading address 2 returns {bit31 = 1, status, length} for the oldest completion and removes it. When the queue is empty it returns 0. Status bits [10:8] give the completion count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_tvalid_i | input | 1 | Stream beat valid |
| s_tready_o | output | 1 | Stream beat ready |
| s_tdata_i | input | 32 | Stream beat data |
| s_tkeep_i | input | 4 | Byte-valid flags of the beat |
| s_tlast_i | input | 1 | Last beat of the packet |
| mem_we_o | output | 1 | Memory word write strobe |
| mem_addr_o | output | 16 | Memory word address |
| mem_data_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte enables |
| mem_stall_i | input | 1 | Memory port cannot take a write this cycle |
| cfg_we_i | input | 1 | Control write strobe |
| cfg_re_i | input | 1 | Control read strobe (pops a completion at address 2) |
| cfg_addr_i | input | 2 | Control register address |
| cfg_wdata_i | input | 32 | Control write data |
| cfg_rdata_o | output | 32 | Control read data (combinational) |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
Two events can fall in the same cycle: a packet completing, which sets the sticky interrupt bit, and a software write-one-to-clear of that bit. The bench provokes this by driving a single-beat TLAST packet and the status-register clear write on the same clock edge, with a free descriptor queued. It then reads the status register and expects the bit still set, the completion counted and irq_o high for one cycle. A clear issued on its own, away from any completion, must leave the bit at 0.

// File: rtl/pkt_cap_pkg.sv
package pkt_cap_pkg;
  typedef enum logic [1:0] {
    RA_BASE = 2'd0,
    RA_CAP  = 2'd1,
    RA_CMPL = 2'd2,
    RA_STAT = 2'd3
  } reg_addr_e;

  localparam int unsigned STAT_W      = 2;
  localparam int unsigned ST_TRUNC    = 0;
  localparam int unsigned ST_EMPTY    = 1;
  localparam int unsigned CMPL_VLD    = 31;
  localparam int unsigned CMPL_ST_LSB = 16;
  localparam int unsigned DCNT_LSB    = 4;
  localparam int unsigned CCNT_LSB    = 8;
endpackage

// File: rtl/pkt_cap_fifo.sv
module pkt_cap_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r9_full_push_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/pkt_cap_wr.sv
module pkt_cap_wr #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CAP_W  = 12,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned KEEP_W = DATA_W / 8,
  localparam int unsigned STAT_W = pkt_cap_pkg::STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic [KEEP_W-1:0] s_tkeep_i,
  input  logic              s_tlast_i,
  input  logic              desc_vld_i,
  input  logic [ADDR_W-1:0] desc_base_i,
  input  logic [CAP_W-1:0]  desc_cap_i,
  output logic              desc_pop_o,
  input  logic              cmpl_full_i,
  output logic              cmpl_push_o,
  output logic [LEN_W-1:0]  cmpl_len_o,
  output logic [STAT_W-1:0] cmpl_stat_o,
  input  logic              mem_stall_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [KEEP_W-1:0] mem_be_o
);
  import pkt_cap_pkg::*;

  logic [CAP_W-1:0] word_q;
  logic [LEN_W-1:0] len_q, beat_bytes;
  logic             disc_q, fits, fire, wr;

  always_comb begin
    beat_bytes = '0;
    for (int i = 0; i < KEEP_W; i++) beat_bytes = beat_bytes + LEN_W'(s_tkeep_i[i]);
  end

  assign fits       = word_q < desc_cap_i;
  assign s_tready_o = desc_vld_i & ~cmpl_full_i & (disc_q | ~mem_stall_i);
  assign fire       = s_tvalid_i & s_tready_o;
  assign wr         = fire & ~disc_q & fits;

  assign mem_we_o   = wr;
  assign mem_addr_o = desc_base_i + ADDR_W'(word_q);
  assign mem_data_o = s_tdata_i;
  assign mem_be_o   = s_tkeep_i;

  assign cmpl_push_o = fire & s_tlast_i;
  assign desc_pop_o  = fire & s_tlast_i;
  assign cmpl_len_o  = len_q + (wr ? beat_bytes : '0);
  always_comb begin
    cmpl_stat_o           = '0;
    cmpl_stat_o[ST_TRUNC] = disc_q | ~fits;
    cmpl_stat_o[ST_EMPTY] = (cmpl_len_o == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      len_q  <= '0;
      disc_q <= 1'b0;
    end else if (fire) begin
      if (s_tlast_i) begin
        word_q <= '0;
        len_q  <= '0;
        disc_q <= 1'b0;
      end else if (wr) begin
        word_q <= word_q + 1'b1;
        len_q  <= len_q + beat_bytes;
      end else begin
        disc_q <= 1'b1;
      end
    end
  end

  a_r2_no_ready_without_desc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !desc_vld_i |-> !s_tready_o);
  a_r2_no_write_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_stall_i |-> !mem_we_o);
  a_r3_write_needs_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (s_tvalid_i && s_tready_o));
  a_r10_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_push_o |-> !cmpl_full_i);
endmodule

// File: rtl/pkt_cap_regs.sv
module pkt_cap_regs #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CAP_W  = 12,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned CNT_W  = 3,
  localparam int unsigned STAT_W = pkt_cap_pkg::STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_re_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              desc_push_o,
  output logic [ADDR_W-1:0] desc_base_o,
  output logic [CAP_W-1:0]  desc_cap_o,
  input  logic [CNT_W-1:0]  desc_cnt_i,
  input  logic              cmpl_vld_i,
  input  logic [LEN_W-1:0]  cmpl_len_i,
  input  logic [STAT_W-1:0] cmpl_stat_i,
  output logic              cmpl_pop_o,
  input  logic [CNT_W-1:0]  cmpl_cnt_i,
  input  logic              done_i,
  output logic              irq_o
);
  import pkt_cap_pkg::*;

  reg_addr_e        ra;
  logic [ADDR_W-1:0] base_q;
  logic              sticky_q, irq_q, clr;
  logic              unused_wdata;

  assign ra           = reg_addr_e'(cfg_addr_i);
  assign unused_wdata = ^cfg_wdata_i;
  assign desc_push_o  = cfg_we_i & (ra == RA_CAP);
  assign desc_base_o  = base_q;
  assign desc_cap_o   = cfg_wdata_i[CAP_W-1:0];
  assign cmpl_pop_o   = cfg_re_i & (ra == RA_CMPL) & cmpl_vld_i;
  assign clr          = cfg_we_i & (ra == RA_STAT) & cfg_wdata_i[0];
  assign irq_o        = irq_q;

  always_comb begin
    cfg_rdata_o = '0;
    case (ra)
      RA_BASE: cfg_rdata_o[ADDR_W-1:0] = base_q;
      RA_CMPL: if (cmpl_vld_i) begin
        cfg_rdata_o[CMPL_VLD]                 = 1'b1;
        cfg_rdata_o[CMPL_ST_LSB +: STAT_W]    = cmpl_stat_i;
        cfg_rdata_o[LEN_W-1:0]                = cmpl_len_i;
      end
      RA_STAT: begin
        cfg_rdata_o[0]                = sticky_q;
        cfg_rdata_o[DCNT_LSB +: CNT_W] = desc_cnt_i;
        cfg_rdata_o[CCNT_LSB +: CNT_W] = cmpl_cnt_i;
      end
      default: cfg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      sticky_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (cfg_we_i && ra == RA_BASE) base_q <= cfg_wdata_i[ADDR_W-1:0];
      irq_q <= done_i;
      if (done_i)   sticky_q <= 1'b1;  // set beats clear
      else if (clr) sticky_q <= 1'b0;
    end
  end

  a_r8_irq_implies_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sticky_q);
  a_r8_clear_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !done_i) |=> !sticky_q);
endmodule

// File: rtl/pkt_capture.sv
module pkt_capture #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned CAP_W      = 12,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned DESC_DEPTH = 4,
  parameter int unsigned CMPL_DEPTH = 4,
  localparam int unsigned KEEP_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic [KEEP_W-1:0] s_tkeep_i,
  input  logic              s_tlast_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic [KEEP_W-1:0] mem_be_o,
  input  logic              mem_stall_i,
  input  logic              cfg_we_i,
  input  logic              cfg_re_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              irq_o
);
  import pkt_cap_pkg::*;

  localparam int unsigned CNT_W  = $clog2(((DESC_DEPTH > CMPL_DEPTH) ? DESC_DEPTH : CMPL_DEPTH) + 1);
  localparam int unsigned DCNT_W = $clog2(DESC_DEPTH + 1);
  localparam int unsigned CCNT_W = $clog2(CMPL_DEPTH + 1);
  localparam int unsigned DESC_W = ADDR_W + CAP_W;
  localparam int unsigned CMPL_W = LEN_W + STAT_W;

  logic              desc_push, desc_pop, desc_full, desc_empty;
  logic [DESC_W-1:0] desc_head;
  logic [DCNT_W-1:0] desc_cnt;
  logic [ADDR_W-1:0] new_base;
  logic [CAP_W-1:0]  new_cap;
  logic              cmpl_push, cmpl_pop, cmpl_full, cmpl_empty;
  logic [CMPL_W-1:0] cmpl_head;
  logic [CCNT_W-1:0] cmpl_cnt;
  logic [LEN_W-1:0]  wr_len;
  logic [STAT_W-1:0] wr_stat;
  logic              unused_desc_full;

  assign unused_desc_full = desc_full;

  pkt_cap_fifo #(.W(DESC_W), .DEPTH(DESC_DEPTH)) u_desc_q (
    .clk_i, .rst_ni,
    .push_i(desc_push), .din_i({new_base, new_cap}),
    .pop_i(desc_pop), .dout_o(desc_head),
    .full_o(desc_full), .empty_o(desc_empty), .count_o(desc_cnt)
  );

  pkt_cap_fifo #(.W(CMPL_W), .DEPTH(CMPL_DEPTH)) u_cmpl_q (
    .clk_i, .rst_ni,
    .push_i(cmpl_push), .din_i({wr_stat, wr_len}),
    .pop_i(cmpl_pop), .dout_o(cmpl_head),
    .full_o(cmpl_full), .empty_o(cmpl_empty), .count_o(cmpl_cnt)
  );

  pkt_cap_wr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CAP_W(CAP_W), .LEN_W(LEN_W)) u_wr (
    .clk_i, .rst_ni,
    .s_tvalid_i, .s_tready_o, .s_tdata_i, .s_tkeep_i, .s_tlast_i,
    .desc_vld_i(~desc_empty),
    .desc_base_i(desc_head[DESC_W-1:CAP_W]),
    .desc_cap_i(desc_head[CAP_W-1:0]),
    .desc_pop_o(desc_pop),
    .cmpl_full_i(cmpl_full), .cmpl_push_o(cmpl_push),
    .cmpl_len_o(wr_len), .cmpl_stat_o(wr_stat),
    .mem_stall_i, .mem_we_o, .mem_addr_o, .mem_data_o, .mem_be_o
  );

  pkt_cap_regs #(.ADDR_W(ADDR_W), .CAP_W(CAP_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_re_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .desc_push_o(desc_push), .desc_base_o(new_base), .desc_cap_o(new_cap),
    .desc_cnt_i(CNT_W'(desc_cnt)),
    .cmpl_vld_i(~cmpl_empty),
    .cmpl_len_i(cmpl_head[LEN_W-1:0]),
    .cmpl_stat_i(cmpl_head[CMPL_W-1:LEN_W]),
    .cmpl_pop_o(cmpl_pop),
    .cmpl_cnt_i(CNT_W'(cmpl_cnt)),
    .done_i(cmpl_push),
    .irq_o
  );

  a_r5_desc_retire_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_tvalid_i && s_tready_o && s_tlast_i && !desc_push) |=> (desc_cnt == $past(desc_cnt) - 1'b1));
endmodule

// File: tb/pkt_capture_test.sv
module pkt_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tvalid = 1'b0, tlast = 1'b0, stall = 1'b0;
  logic [31:0] tdata = '0;
  logic [3:0]  tkeep = '0;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        tready, mem_we, irq;
  logic [15:0] mem_addr;
  logic [31:0] mem_data, cfg_rdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_q [int unsigned];
  int          checks = 0, errors = 0;
  bit          stall_mode = 1'b0;

  always #4 clk = ~clk;

  pkt_capture uut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_tvalid_i(tvalid), .s_tready_o(tready), .s_tdata_i(tdata),
    .s_tkeep_i(tkeep), .s_tlast_i(tlast),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_be_o(mem_be), .mem_stall_i(stall),
    .cfg_we_i(cfg_we), .cfg_re_i(cfg_re), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .irq_o(irq)
  );

  function automatic logic [31:0] mem_rd(input int unsigned a);
    return mem_q.exists(a) ? mem_q[a] : 32'h0;
  endfunction

  always @(posedge clk) begin : mem_model
    logic [31:0] w;
    if (mem_we) begin
      w = mem_rd(mem_addr);
      for (int b = 0; b < 4; b++) if (mem_be[b]) w[8*b +: 8] = mem_data[8*b +: 8];
      mem_q[mem_addr] = w;
    end
  end

  function automatic logic [31:0] pat(input int seed, input int i);
    return 32'hC0DE_0000 | (seed << 8) | i;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_re = 1'b0;
  endtask

  task automatic push_desc(input logic [15:0] base, input logic [11:0] cap);
    reg_wr(2'd0, 32'(base));
    reg_wr(2'd1, 32'(cap));
  endtask

  task automatic send_pkt(input int seed, input int nbeats, input logic [3:0] last_keep);
    for (int i = 0; i < nbeats; i++) begin
      @(negedge clk);
      tvalid = 1'b1; tdata = pat(seed, i);
      tlast = (i == nbeats - 1);
      tkeep = tlast ? last_keep : 4'hF;
      forever begin
        if (stall_mode) stall = ~stall;
        #1;
        if (stall && stall_mode) chk("R2 ready while stalled", 32'(tready), 32'h0);
        if (tready) break;
        @(negedge clk);
      end
      @(posedge clk);
    end
    @(negedge clk);
    tvalid = 1'b0; tlast = 1'b0; stall = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1;
    chk("R1 tready", 32'(tready), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    reg_rd(2'd3, d); chk("R1 status", d, 32'h0);
    reg_rd(2'd2, d); chk("R1 completion empty (R10)", d, 32'h0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    int bad = 0;
    @(negedge clk); tvalid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1 if (tready) bad++;
      @(negedge clk);
    end
    tvalid = 1'b0;
    chk("R2 no descriptor ready count", 32'(bad), 32'h0);
    push_desc(16'h100, 12'd8);
    send_pkt(1, 3, 4'b0011);
    #1 chk("R8 irq pulse high", 32'(irq), 32'h1);
    @(negedge clk); #1 chk("R8 irq pulse low", 32'(irq), 32'h0);
    chk("R3 word0", mem_rd(16'h100), pat(1, 0));
    chk("R3 word1", mem_rd(16'h101), pat(1, 1));
    chk("R3 last word masked", mem_rd(16'h102), pat(1, 2) & 32'h0000_FFFF);
    reg_rd(2'd3, d); chk("R8 sticky set, R10 count", d, 32'h0000_0101);
    reg_rd(2'd2, d); chk("R4 length 10", d, 32'h8000_000A);
    reg_wr(2'd3, 32'h1);
    reg_rd(2'd3, d); chk("R8 cleared by W1C", d, 32'h0);
  endtask

  task automatic t_stall;
    logic [31:0] d;
    push_desc(16'h200, 12'd4);
    push_desc(16'h300, 12'd4);
    reg_rd(2'd3, d); chk("R9 two descriptors", d, 32'h0000_0020);
    stall_mode = 1'b1;
    send_pkt(2, 2, 4'hF);
    send_pkt(3, 4, 4'b0111);
    stall_mode = 1'b0;
    chk("R5 first buffer", mem_rd(16'h201), pat(2, 1));
    chk("R5 second buffer start", mem_rd(16'h300), pat(3, 0));
    chk("R3 stalled last word", mem_rd(16'h303), pat(3, 3) & 32'h00FF_FFFF);
    reg_rd(2'd2, d); chk("R4 length 8", d, 32'h8000_0008);
    reg_rd(2'd2, d); chk("R4 length 15", d, 32'h8000_000F);
    reg_wr(2'd3, 32'h1);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    push_desc(16'h400, 12'd2);
    push_desc(16'h500, 12'd4);
    push_desc(16'h600, 12'd0);
    send_pkt(4, 5, 4'hF);
    send_pkt(5, 1, 4'b0001);
    send_pkt(6, 2, 4'hF);
    chk("R6 kept word", mem_rd(16'h401), pat(4, 1));
    chk("R6 no write past capacity", mem_rd(16'h402), 32'h0);
    chk("R6 next packet captured", mem_rd(16'h500), pat(5, 0) & 32'h0000_00FF);
    chk("R7 zero capacity untouched", mem_rd(16'h600), 32'h0);
    reg_rd(2'd2, d); chk("R6 truncated entry", d, 32'h8001_0008);
    reg_rd(2'd2, d); chk("R6 following entry", d, 32'h8000_0001);
    reg_rd(2'd2, d); chk("R7 empty and truncated", d, 32'h8003_0000);
    reg_wr(2'd3, 32'h1);
  endtask

  task automatic t_queues;
    logic [31:0] d;
    for (int i = 0; i < 5; i++) push_desc(16'(16'h700 + 16 * i), 12'd1);
    reg_rd(2'd3, d); chk("R9 queue holds four", d, 32'h0000_0040);
    for (int i = 0; i < 4; i++) send_pkt(7 + i, 1, 4'hF);
    chk("R5 fourth buffer", mem_rd(16'h730), pat(10, 0));
    chk("R9 fifth push ignored", mem_rd(16'h740), 32'h0);
    reg_rd(2'd3, d); chk("R10 completion queue full", d, 32'h0000_0401);
    push_desc(16'h750, 12'd1);
    #1 chk("R10 ready low when completions full", 32'(tready), 32'h0);
    reg_rd(2'd2, d); chk("R10 pop oldest", d, 32'h8000_0004);
    #1 chk("R2 ready back after pop", 32'(tready), 32'h1);
    for (int i = 0; i < 3; i++) reg_rd(2'd2, d);
    chk("R10 last pop", d, 32'h8000_0004);
    reg_wr(2'd3, 32'h1);
    reg_rd(2'd3, d); chk("R8 clear leaves one descriptor", d, 32'h0000_0010);
  endtask

  task automatic t_set_vs_clear;
    logic [31:0] d;
    @(negedge clk);
    tvalid = 1'b1; tlast = 1'b1; tkeep = 4'hF; tdata = pat(11, 0);
    cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'h1;
    #1 chk("R8 ready for colliding beat", 32'(tready), 32'h1);
    @(negedge clk);
    tvalid = 1'b0; tlast = 1'b0; cfg_we = 1'b0;
    #1 chk("R8 irq on collision", 32'(irq), 32'h1);
    reg_rd(2'd3, d); chk("R8 set wins over clear", d, 32'h0000_0101);
    reg_rd(2'd2, d); chk("R4 collision length", d, 32'h8000_0004);
    chk("R3 collision word", mem_rd(16'h750), pat(11, 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_stall();
    t_overflow();
    t_queues();
    t_set_vs_clear();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule